// File: doc/BRIEF.md
# Two-Symbol Streaming ANS Encoder

This block turns a message over a two-letter alphabet (letter a with weight one quarter, letter b with weight three quarters) into a binary bitstream. It uses asymmetric numeral system coding with a 5-bit state that always sits in 16..31. The message is offered one letter at a time, last letter first. For each letter the encoder first sheds low state bits onto a serial output until the state falls into the range that letter can be coded from. It then replaces the state with the coded value. The state starts at 16.

When the caller asks to finish, the block presents the current state on a separate handshake port. A decoder needs that value as its starting point. After the handoff the block reloads 16 for the next message.

An optional raw side channel can carry a fixed-width subtype tag with every a. Those tag bits go out just before the a is coded, so a decoder finds them directly after it decodes the a. Bits leave in emission order. Reversing the stream for transmission is done outside the block.

Top module: `ansEncoder`

## Requirements
- R1: After reset the state is 16, `symReady` is 1, and both `outValid` and `finValid` are 0. A finish request issued at once reports 16.
- R2: Coding a letter maps the state x to 4x for a (`symIsB`=0) and to 4*floor(x/3) + (x mod 3) + 1 for b (`symIsB`=1).
- R3: Before coding, while the state lies outside 4..7 for a or outside 12..23 for b, the block emits x mod 2 on `outBit` and halves the state (floor). One bit moves per cycle in which `outValid` and `outReady` are both 1.
- R4: Offering a, b, b, a, b from state 16 emits 0,0,0,1,0 and leaves state 19.
- R5: If `rawMode` is 1 when an a is accepted, the SUB_W bits of `symSub` are emitted before that letter's renormalisation bits, bit 0 first. A b, or an a accepted with `rawMode` 0, emits no tag bits.
- R6: `symReady` is 1 only when no tag or renormalisation bit is owed and the previous letter has been coded. While `outValid` is 1, `symReady` is 0.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outBit` holds its value.
- R8: A `finishReq` seen in an idle cycle with `symValid` at 0 raises `finValid` with `finState` equal to the current state. After the `finValid`/`finReady` handshake, the state is 16.
- R9: If `symValid` and `finishReq` are both 1 in the same idle cycle, the letter is accepted first. The finish is taken once that letter is fully coded, so `finState` includes it.
- R10: While `finValid` is 1 and `finReady` is 0, `finState` holds, `finValid` stays 1 and `symReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A letter is offered |
| symReady | output | 1 | Block takes a letter or finish request this cycle |
| symIsB | input | 1 | 1 = letter b, 0 = letter a |
| symSub | input | SUB_W | Subtype tag carried with an a |
| rawMode | input | 1 | Emit the tag for this a |
| finishReq | input | 1 | Request the final state (held until handed off) |
| outValid | output | 1 | A bit is offered on outBit |
| outReady | input | 1 | Sink takes the bit |
| outBit | output | 1 | Serial output bit |
| finValid | output | 1 | Final state is offered |
| finReady | input | 1 | Sink takes the final state |
| finState | output | 5 | Final coder state |

## Verification
Two functions can fall in the same cycle: accepting a letter and accepting a finish request. Both are only taken while the block is idle. The bench raises `symValid` and `finishReq` on the same idle edge and keeps the request held. It expects the letter's bits and its coded state to show up in `finState` before the block reloads 16. The rest of the run sweeps every letter pattern up to six letters long, with and without tags and under random back-pressure. The emitted bits and the final state are compared against an arithmetic model of the coding rules.

// File: rtl/ansEncPkg.sv
package ansEncPkg;
  localparam int STATE_W    = 5;
  localparam int STATE_INIT = 16;
  localparam int A_LO = 4;
  localparam int A_HI = 7;
  localparam int B_LO = 12;
  localparam int B_HI = 23;

  typedef struct packed {
    logic loadSym;
    logic shiftRaw;
    logic shiftState;
    logic applyCode;
    logic restart;
  } encStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EMIT  = 2'd1,
    ST_FINAL = 2'd2
  } encPhase_t;
endpackage

// File: rtl/ansEncDatapath.sv
module ansEncDatapath
  import ansEncPkg::*;
#(
  parameter int SUB_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  encStrobe_t         strobe,
  input  logic               symIsB,
  input  logic [SUB_W-1:0]   symSub,
  input  logic               rawMode,
  output logic [STATE_W-1:0] stateQ,
  output logic               inRange,
  output logic               rawPending,
  output logic               outBit
);
  localparam int CNT_W = $clog2(SUB_W + 1);

  logic               symBQ;
  logic [SUB_W-1:0]   subQ;
  logic [CNT_W-1:0]   rawCntQ;
  logic [STATE_W-1:0] quot3, rem3, codeA, codeB, coded;

  // Precursor range of the latched letter
  always_comb begin
    if (symBQ) inRange = (stateQ >= STATE_W'(B_LO)) && (stateQ <= STATE_W'(B_HI));
    else       inRange = (stateQ >= STATE_W'(A_LO)) && (stateQ <= STATE_W'(A_HI));
  end

  // Coding functions
  assign quot3 = stateQ / STATE_W'(3);
  assign rem3  = stateQ % STATE_W'(3);
  assign codeA = STATE_W'({stateQ, 2'b00});
  assign codeB = STATE_W'({quot3, 2'b00} + {2'b00, rem3} + (STATE_W + 2)'(1));
  assign coded = symBQ ? codeB : codeA;

  assign rawPending = (rawCntQ != '0);
  assign outBit     = rawPending ? subQ[0] : stateQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= STATE_W'(STATE_INIT);
      symBQ   <= 1'b0;
      subQ    <= '0;
      rawCntQ <= '0;
    end else begin
      if (strobe.loadSym) begin
        symBQ   <= symIsB;
        subQ    <= symSub;
        rawCntQ <= (rawMode && !symIsB) ? CNT_W'(SUB_W) : '0;
      end
      if (strobe.shiftRaw) begin
        subQ    <= subQ >> 1;
        rawCntQ <= rawCntQ - CNT_W'(1);
      end
      if (strobe.shiftState) stateQ <= stateQ >> 1;
      else if (strobe.applyCode) stateQ <= coded;
      else if (strobe.restart) stateQ <= STATE_W'(STATE_INIT);
    end
  end
endmodule

// File: rtl/ansEncControl.sv
module ansEncControl
  import ansEncPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic       finishReq,
  input  logic       outReady,
  input  logic       finReady,
  input  logic       inRange,
  input  logic       rawPending,
  output logic       symReady,
  output logic       outValid,
  output logic       finValid,
  output encStrobe_t strobe
);
  encPhase_t phaseQ, phaseD;

  always_comb begin
    phaseD   = phaseQ;
    strobe   = '0;
    symReady = 1'b0;
    outValid = 1'b0;
    finValid = 1'b0;
    unique case (phaseQ)
      ST_IDLE: begin
        symReady = 1'b1;
        if (symValid) begin
          strobe.loadSym = 1'b1;
          phaseD = ST_EMIT;
        end else if (finishReq) begin
          phaseD = ST_FINAL;
        end
      end
      ST_EMIT: begin
        if (rawPending) begin
          outValid = 1'b1;
          strobe.shiftRaw = outReady;
        end else if (!inRange) begin
          outValid = 1'b1;
          strobe.shiftState = outReady;
        end else begin
          strobe.applyCode = 1'b1;
          phaseD = ST_IDLE;
        end
      end
      ST_FINAL: begin
        finValid = 1'b1;
        if (finReady) begin
          strobe.restart = 1'b1;
          phaseD = ST_IDLE;
        end
      end
      default: phaseD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= ST_IDLE;
    else       phaseQ <= phaseD;
  end
endmodule

// File: rtl/ansEncoder.sv
module ansEncoder
  import ansEncPkg::*;
#(
  parameter int SUB_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               symValid,
  output logic               symReady,
  input  logic               symIsB,
  input  logic [SUB_W-1:0]   symSub,
  input  logic               rawMode,
  input  logic               finishReq,
  output logic               outValid,
  input  logic               outReady,
  output logic               outBit,
  output logic               finValid,
  input  logic               finReady,
  output logic [STATE_W-1:0] finState
);
  encStrobe_t         strobe;
  logic [STATE_W-1:0] stateQ;
  logic               inRange, rawPending;

  ansEncControl u_ctrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .finishReq(finishReq),
    .outReady(outReady), .finReady(finReady), .inRange(inRange),
    .rawPending(rawPending), .symReady(symReady), .outValid(outValid),
    .finValid(finValid), .strobe(strobe)
  );

  ansEncDatapath #(.SUB_W(SUB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .symIsB(symIsB),
    .symSub(symSub), .rawMode(rawMode), .stateQ(stateQ),
    .inRange(inRange), .rawPending(rawPending), .outBit(outBit)
  );

  assign finState = stateQ;
endmodule

// File: rtl/ansEncChecker.sv
module ansEncChecker
  import ansEncPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               symReady,
  input logic               outValid,
  input logic               outReady,
  input logic               outBit,
  input logic               finValid,
  input logic               finReady,
  input logic [STATE_W-1:0] finState,
  input logic [STATE_W-1:0] stateQ,
  input logic               rawPending
);
  a_r6_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    symReady |-> !outValid && !finValid);

  a_r7_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBit));

  a_r10_final_hold: assert property (@(posedge clk) disable iff (!rstN)
    finValid && !finReady |=> finValid && $stable(finState));

  a_r3_halve_on_emit: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !rawPending |=> stateQ == ($past(stateQ) >> 1));

  a_r5_tag_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    outValid && rawPending |=> $stable(stateQ));

  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    finValid && finReady |=> stateQ == STATE_W'(STATE_INIT));

  a_r8_final_in_interval: assert property (@(posedge clk) disable iff (!rstN)
    finValid |-> finState >= STATE_W'(STATE_INIT));
endmodule

bind ansEncoder ansEncChecker u_chk (
  .clk(clk), .rstN(rstN), .symReady(symReady), .outValid(outValid),
  .outReady(outReady), .outBit(outBit), .finValid(finValid),
  .finReady(finReady), .finState(finState), .stateQ(stateQ),
  .rawPending(rawPending)
);

// File: tb/test_ansEncoder.sv
module test_ansEncoder;
  localparam int SUB_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0, symIsB = 1'b0, rawMode = 1'b0, finishReq = 1'b0;
  logic [SUB_W-1:0] symSub = '0;
  logic outReady = 1'b1, finReady = 1'b0;
  logic symReady, outValid, outBit, finValid;
  logic [4:0] finState;

  int checks = 0, errors = 0, cyc = 0;
  int gotN = 0;
  logic gotBits [64];
  logic bpOn = 1'b0, manualReady = 1'b0, manualVal = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  ansEncoder #(.SUB_W(SUB_W)) i_ansEncoder (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symReady(symReady),
    .symIsB(symIsB), .symSub(symSub), .rawMode(rawMode), .finishReq(finishReq),
    .outValid(outValid), .outReady(outReady), .outBit(outBit),
    .finValid(finValid), .finReady(finReady), .finState(finState)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  always @(posedge clk)
    if (rstN && outValid && outReady) begin
      if (gotN < 64) gotBits[gotN] = outBit;
      gotN++;
    end

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (manualReady) outReady = manualVal;
    else outReady = bpOn ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendSym(input logic b, input logic [SUB_W-1:0] s, input logic r);
    @(negedge clk);
    while (!symReady) @(negedge clk);
    symIsB = b; symSub = s; rawMode = r; symValid = 1'b1;
    @(negedge clk);
    symValid = 1'b0;
  endtask

  task automatic doFinish(output int st);
    @(negedge clk);
    while (!symReady) @(negedge clk);
    finishReq = 1'b1;
    @(negedge clk);
    while (!finValid) @(negedge clk);
    finishReq = 1'b0;
    st = int'(finState);
    @(negedge clk);
    @(negedge clk);
    chk(finValid && int'(finState) == st && !symReady, "R10 final held", int'(finState), st);
    finReady = 1'b1;
    @(negedge clk);
    finReady = 1'b0;
  endtask

  function automatic int codeOf(input bit b, input int x);
    return b ? 4 * (x / 3) + (x % 3) + 1 : 4 * x;
  endfunction

  // Model and drive one message; letters pat[0] first
  task automatic runSeq(input int n, input int pat, input bit raw, input int subs, input string tag);
    int x = 16;
    int expN = 0;
    bit expBits [64];
    int st;
    bit ok;
    for (int i = 0; i < n; i++) begin
      bit b = pat[i];
      logic [SUB_W-1:0] s = SUB_W'(subs >> (2 * i));
      if (raw && !b)
        for (int k = 0; k < SUB_W; k++) begin expBits[expN] = s[k]; expN++; end
      while (b ? (x < 12 || x > 23) : (x < 4 || x > 7)) begin
        expBits[expN] = x[0]; expN++; x = x / 2;
      end
      x = codeOf(b, x);
    end
    gotN = 0;
    for (int i = 0; i < n; i++) sendSym(pat[i], SUB_W'(subs >> (2 * i)), raw);
    doFinish(st);
    ok = (gotN == expN);
    for (int i = 0; i < expN && i < gotN; i++) if (gotBits[i] !== expBits[i]) ok = 0;
    chk(ok, {tag, " bitstream"}, gotN, expN);
    chk(st == x, {tag, " final state"}, st, x);
  endtask

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(symReady && !outValid && !finValid, "R1 reset handshake", {symReady, outValid, finValid}, 3'b100);
    doFinish(st);
    chk(st == 16, "R1 initial state", st, 16);

    // R2 single letters from 16
    runSeq(1, 1, 0, 0, "R2 b from 16");
    runSeq(1, 0, 0, 0, "R2 a from 16");

    // R4 worked example: a,b,b,a,b offered
    runSeq(5, 5'b10110, 0, 0, "R4 example");

    // R5 tag before renorm bits, bit 0 first: a, tag 2'b10 -> 0,1,0,0
    runSeq(1, 0, 1, 2, "R5 tag on a");
    runSeq(1, 1, 1, 3, "R5 no tag on b");

    // R6/R7 stall: hold outReady low during an a from 16
    manualReady = 1'b1; manualVal = 1'b0;
    gotN = 0;
    sendSym(1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    chk(outValid && !symReady && outBit == 1'b0, "R6 R7 stalled bit", {outValid, symReady, outBit}, 3'b100);
    manualReady = 1'b0;
    doFinish(st);
    chk(st == 16 && gotN == 2, "R3 after stall", st, 16);

    // R9 letter and finish in the same idle cycle
    @(negedge clk);
    while (!symReady) @(negedge clk);
    symIsB = 1'b1; rawMode = 1'b0; symValid = 1'b1; finishReq = 1'b1;
    @(negedge clk);
    symValid = 1'b0;
    while (!finValid) @(negedge clk);
    chk(int'(finState) == 22, "R9 letter before finish", int'(finState), 22);
    finishReq = 1'b0;
    finReady = 1'b1;
    @(negedge clk);
    finReady = 1'b0;
    doFinish(st);
    chk(st == 16, "R8 restart at 16", st, 16);

    // R3 sweep: every pattern up to six letters, tags on and off
    for (int len = 1; len <= 6; len++)
      for (int p = 0; p < (1 << len); p++)
        for (int r = 0; r < 2; r++) begin
          bpOn = p[0] ^ len[0] ^ r[0];
          runSeq(len, p, r[0], p * 7 + len, "R3 R5 sweep");
        end
    bpOn = 1'b0;
    summary();
  end
endmodule